// File: doc/BRIEF.md
# Debug Memory Window Access Gate

This block sits between a processor core's load/store/fetch request channel and the rest of the memory system. It watches every core request and classifies its 64-bit virtual address. Requests that land in a reserved 2 MiB debug segment at the top of the address space never reach the external memory port. Inside that segment, the lower half is a probe-serviced memory window and the upper half is a debug register window. Every other address goes straight to the memory port with no added latency.

A request into the probe-serviced memory window stalls the core. The block latches the 21-bit offset, the direction and the store data, and raises a pending flag that a JTAG probe polls. The probe finishes the access in one of two ways. It can write 0 to the pending bit, or it can issue a fast-data completion, which works only when the offset lies in the small fast-data area at the bottom of the window. For a load, the probe supplies the data in the same cycle. The core's request channel is valid/ready. Back-pressure has these rules:
- The core holds address, direction and data stable while `core_req_valid` is high and `core_req_ready` is low.
- Read data is valid only in the cycle where both are high.

Top module: `dbgwin_gate`

## Requirements
- R1: After reset, `pend`, `stall`, `probe_err` and `core_req_ready` (with no request) are 0.
- R2: The debug segment is 0xFFFF_FFFF_FF20_0000 to 0xFFFF_FFFF_FF3F_FFFF. Offset bit 20 = 0 selects the memory window and 1 selects the register window. `pend_off` holds address bits [20:0].
- R3: A memory-window request with nothing pending raises `stall` and keeps `core_req_ready` low in that cycle. `pend` is 1 from the next cycle.
- R4: While pending, `dir` is 0 for a core read and 1 for a core write.
- R5: A probe write (`probe_wr`) with `probe_val` = 1 has no effect: `pend` stays 1 and the core stays stalled.
- R6: A probe write with `probe_val` = 0 while pending completes the access. In that cycle `core_req_ready` is 1, `stall` is 0 and `core_rdata` equals `probe_rdata`. `pend` is 0 from the next cycle.
- R7: `fd_ok` = `pend` AND `pend_off` < 16. A `fd_strobe` with `fd_bit` = 0 while `fd_ok` completes the access exactly as R6 does. With `fd_bit` = 1, or with `fd_ok` = 0, there is no effect.
- R8: A request outside the segment drives `mem_req_valid` in the same cycle. `core_req_ready` and `core_rdata` follow `mem_req_ready` and `mem_rdata`, and `stall` stays 0.
- R9: A register-window request is accepted in the same cycle with `core_rdata` = 0. It raises neither `mem_req_valid` nor `pend`.
- R10: While pending, `pend_off` and `pend_wdata` stay stable until completion.
- R11: A probe write of 0 with nothing pending sets `probe_err` for exactly the next cycle.
- R12: A probe clear and a fast-data completion in the same cycle complete the access once, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req_valid | input | 1 | Core request valid |
| core_req_ready | output | 1 | Request accepted; read data valid |
| core_addr | input | AW | Virtual address |
| core_we | input | 1 | 1 = write, 0 = read/fetch |
| core_wdata | input | DW | Store data |
| core_rdata | output | DW | Load/fetch data |
| mem_req_valid | output | 1 | Forwarded request to memory |
| mem_req_ready | input | 1 | Memory accepts |
| mem_addr | output | AW | Forwarded address |
| mem_we | output | 1 | Forwarded direction |
| mem_wdata | output | DW | Forwarded store data |
| mem_rdata | input | DW | Memory read data |
| stall | output | 1 | Core is held on a debug-window access |
| pend | output | 1 | Access pending for the probe |
| dir | output | 1 | Pending direction (1 = core write) |
| pend_off | output | OFFW | Latched window offset |
| pend_wdata | output | DW | Latched store data |
| probe_wr | input | 1 | Probe writes the pending bit |
| probe_val | input | 1 | Value written to the pending bit |
| probe_rdata | input | DW | Data the probe supplies for a pending read |
| fd_strobe | input | 1 | Fast-data scan completes this cycle |
| fd_bit | input | 1 | Fast-data bit shifted in (0 = complete) |
| fd_ok | output | 1 | Fast-data completion would succeed |
| probe_err | output | 1 | Clear written with nothing pending |

## Verification
A register-style clear and a fast-data completion can arrive in the same cycle. The bench provokes this by raising `probe_wr` with value 0 and `fd_strobe` with bit 0 together on a pending access in the fast-data area. It judges the result as one completion: a single ready pulse carrying the probe data, `pend` low afterwards, and no `probe_err`. A second collision also gets a directed case: a clear written in the very cycle a new memory-window request is captured. That clear must raise the error flag and must not cancel the capture.

// File: rtl/dbgwin_pkg.sv
package dbgwin_pkg;
  typedef enum logic [1:0] {
    RGN_MEM  = 2'd0,
    RGN_DMEM = 2'd1,
    RGN_DREG = 2'd2
  } rgn_e;
endpackage

// File: rtl/dbgwin_decode.sv
module dbgwin_decode
  import dbgwin_pkg::*;
#(
  parameter int AW = 64,
  parameter int OFFW = 21,
  parameter logic [AW-1:0] SEG_BASE = 64'hFFFF_FFFF_FF20_0000
) (
  input  logic [AW-1:0]   addr,
  output rgn_e            rgn,
  output logic [OFFW-1:0] off
);
  localparam int TAGW = AW - OFFW;
  localparam logic [TAGW-1:0] SEG_TAG = SEG_BASE[AW-1:OFFW];

  logic seg_hit;
  assign seg_hit = (addr[AW-1:OFFW] == SEG_TAG);
  assign off     = addr[OFFW-1:0];

  always_comb begin
    if (!seg_hit)            rgn = RGN_MEM;
    else if (addr[OFFW-1])   rgn = RGN_DREG;
    else                     rgn = RGN_DMEM;
  end
endmodule

// File: rtl/dbgwin_pend.sv
module dbgwin_pend #(
  parameter int DW = 32,
  parameter int OFFW = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            cap_we,
  input  logic [OFFW-1:0] cap_off,
  input  logic [DW-1:0]   cap_wdata,
  input  logic            done,
  output logic            pend,
  output logic            dir,
  output logic [OFFW-1:0] off,
  output logic [DW-1:0]   wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      dir   <= 1'b0;
      off   <= '0;
      wdata <= '0;
    end else if (capture) begin
      pend  <= 1'b1;
      dir   <= cap_we;
      off   <= cap_off;
      wdata <= cap_wdata;
    end else if (done) begin
      pend  <= 1'b0;
    end
  end
endmodule

// File: rtl/dbgwin_release.sv
module dbgwin_release #(
  parameter int OFFW = 21,
  parameter int FD_BYTES = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend,
  input  logic [OFFW-1:0] off,
  input  logic            probe_wr,
  input  logic            probe_val,
  input  logic            fd_strobe,
  input  logic            fd_bit,
  output logic            done,
  output logic            fd_ok,
  output logic            probe_err
);
  localparam logic [OFFW-1:0] FD_LIMIT = OFFW'(FD_BYTES);

  logic clr_req, fd_req;
  assign clr_req = probe_wr && !probe_val;
  assign fd_ok   = pend && (off < FD_LIMIT);
  assign fd_req  = fd_strobe && !fd_bit && fd_ok;
  assign done    = pend && (clr_req || fd_req);

  always_ff @(posedge clk) begin
    if (!rst_n) probe_err <= 1'b0;
    else        probe_err <= clr_req && !pend;
  end
endmodule

// File: rtl/dbgwin_gate.sv
module dbgwin_gate
  import dbgwin_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter int OFFW = 21,
  parameter int FD_BYTES = 16,
  parameter logic [AW-1:0] SEG_BASE = 64'hFFFF_FFFF_FF20_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_req_valid,
  output logic            core_req_ready,
  input  logic [AW-1:0]   core_addr,
  input  logic            core_we,
  input  logic [DW-1:0]   core_wdata,
  output logic [DW-1:0]   core_rdata,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_we,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            stall,
  output logic            pend,
  output logic            dir,
  output logic [OFFW-1:0] pend_off,
  output logic [DW-1:0]   pend_wdata,
  input  logic            probe_wr,
  input  logic            probe_val,
  input  logic [DW-1:0]   probe_rdata,
  input  logic            fd_strobe,
  input  logic            fd_bit,
  output logic            fd_ok,
  output logic            probe_err
);
  rgn_e            rgn;
  logic [OFFW-1:0] req_off;
  logic            capture, done;

  dbgwin_decode #(.AW(AW), .OFFW(OFFW), .SEG_BASE(SEG_BASE)) u_dec (
    .addr (core_addr),
    .rgn  (rgn),
    .off  (req_off)
  );

  assign capture = core_req_valid && (rgn == RGN_DMEM) && !pend;

  dbgwin_pend #(.DW(DW), .OFFW(OFFW)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .cap_we    (core_we),
    .cap_off   (req_off),
    .cap_wdata (core_wdata),
    .done      (done),
    .pend      (pend),
    .dir       (dir),
    .off       (pend_off),
    .wdata     (pend_wdata)
  );

  dbgwin_release #(.OFFW(OFFW), .FD_BYTES(FD_BYTES)) u_rel (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend),
    .off       (pend_off),
    .probe_wr  (probe_wr),
    .probe_val (probe_val),
    .fd_strobe (fd_strobe),
    .fd_bit    (fd_bit),
    .done      (done),
    .fd_ok     (fd_ok),
    .probe_err (probe_err)
  );

  assign mem_req_valid = core_req_valid && (rgn == RGN_MEM);
  assign mem_addr      = core_addr;
  assign mem_we        = core_we;
  assign mem_wdata     = core_wdata;
  assign stall         = (pend || capture) && !done;

  always_comb begin
    core_req_ready = 1'b0;
    core_rdata     = '0;
    if (core_req_valid) begin
      unique case (rgn)
        RGN_MEM: begin
          core_req_ready = mem_req_ready;
          core_rdata     = mem_rdata;
        end
        RGN_DMEM: begin
          core_req_ready = done;
          core_rdata     = probe_rdata;
        end
        default: begin
          core_req_ready = 1'b1;
          core_rdata     = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dbgwin_gate_chk.sv
module dbgwin_gate_chk #(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter int OFFW = 21,
  parameter logic [AW-1:0] SEG_BASE = 64'hFFFF_FFFF_FF20_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_req_valid,
  input logic            core_req_ready,
  input logic [AW-1:0]   core_addr,
  input logic            core_we,
  input logic            mem_req_valid,
  input logic            stall,
  input logic            pend,
  input logic            dir,
  input logic [OFFW-1:0] pend_off,
  input logic [DW-1:0]   pend_wdata,
  input logic            probe_wr,
  input logic            probe_val,
  input logic            fd_strobe,
  input logic            fd_bit,
  input logic            probe_err
);
  localparam logic [AW-1:0] DM_HI  = SEG_BASE + (AW'(1) << (OFFW - 1)) - AW'(1);
  localparam logic [AW-1:0] SEG_HI = SEG_BASE + (AW'(1) << OFFW) - AW'(1);

  logic in_dm, in_seg, any_finish;
  assign in_dm  = (core_addr >= SEG_BASE) && (core_addr <= DM_HI);
  assign in_seg = (core_addr >= SEG_BASE) && (core_addr <= SEG_HI);
  assign any_finish = (probe_wr && !probe_val) || (fd_strobe && !fd_bit);

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && in_dm && !pend) |-> (stall && !core_req_ready));
  p_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && in_dm && !pend) |=> pend);
  p_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && in_dm && !pend) |=> (dir == $past(core_we)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !any_finish) |-> (!core_req_ready && stall));
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !any_finish) |=> pend);
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && probe_wr && !probe_val) |=> !pend);
  p_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && !in_seg && !pend) |-> (!stall && mem_req_valid));
  p_noleak_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req_valid && in_seg) |-> !mem_req_valid);
  p_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !any_finish) |=> ($stable(pend_off) && $stable(pend_wdata)));
  p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_wr && !probe_val && !pend) |=> probe_err);
  p_noerr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && probe_wr) |=> !probe_err);
endmodule

bind dbgwin_gate dbgwin_gate_chk #(.AW(AW), .DW(DW), .OFFW(OFFW), .SEG_BASE(SEG_BASE)) u_chk (.*);

// File: tb/dbgwin_gate_test.sv
`timescale 1ns/1ps
module dbgwin_gate_test;
  localparam int AW = 64, DW = 32, OFFW = 21;
  localparam logic [63:0] DM_BASE = 64'hFFFF_FFFF_FF20_0000;
  localparam logic [63:0] DM_TOP  = 64'hFFFF_FFFF_FF2F_FFFF;
  localparam logic [63:0] DR_BASE = 64'hFFFF_FFFF_FF30_0000;
  localparam logic [63:0] DR_TOP  = 64'hFFFF_FFFF_FF3F_FFFF;

  logic clk = 0, rst_n = 0;
  logic core_req_valid = 0, core_we = 0, core_req_ready;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0, core_rdata;
  logic mem_req_valid, mem_req_ready = 0, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic stall, pend, dir, fd_ok, probe_err;
  logic [OFFW-1:0] pend_off;
  logic [DW-1:0] pend_wdata, probe_rdata = '0;
  logic probe_wr = 0, probe_val = 0, fd_strobe = 0, fd_bit = 0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbgwin_gate uut (.*);

  function automatic int region(input logic [63:0] a);
    if (a >= DM_BASE && a <= DM_TOP) return 1;
    if (a >= DR_BASE && a <= DR_TOP) return 2;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    core_req_valid = 0; probe_wr = 0; probe_val = 0; fd_strobe = 0; fd_bit = 0;
  endtask

  // Access into the probe-serviced window; mode 0 = clear, 1 = fast data, 2 = both
  task automatic dm_access(input logic [63:0] a, input bit we, input logic [31:0] wd,
                           input logic [31:0] pd, input int mode, input int waits);
    logic [20:0] eo = a[20:0];
    bit fdable = (eo < 21'd16);
    @(negedge clk);
    core_req_valid = 1; core_addr = a; core_we = we; core_wdata = wd;
    #1;
    chk(stall == 1 && core_req_ready == 0, "R3 stall on capture", {62'd0, stall, core_req_ready}, 64'h2);
    @(negedge clk); #1;
    chk(pend == 1, "R3 pend set", pend, 1);
    chk(dir == we, "R4 direction", dir, we);
    chk(pend_off == eo, "R2 offset", pend_off, eo);
    chk(fd_ok == fdable, "R7 fd_ok flag", fd_ok, fdable);
    for (int i = 0; i < waits; i++) begin
      probe_wr = 1; probe_val = 1; fd_strobe = (i % 2); fd_bit = 1;
      #1;
      chk(core_req_ready == 0 && stall == 1, "R5 write-one ignored", core_req_ready, 0);
      @(negedge clk); #1;
      chk(pend == 1, "R5 pend kept", pend, 1);
      chk(pend_off == eo && pend_wdata == wd, "R10 latched stable", pend_wdata, wd);
      probe_wr = 0; fd_strobe = 0;
    end
    if (mode != 0 && !fdable) begin
      fd_strobe = 1; fd_bit = 0;
      #1;
      chk(core_req_ready == 0, "R7 fast-data outside area refused", core_req_ready, 0);
      @(negedge clk); #1;
      chk(pend == 1, "R7 pend kept after refused fast data", pend, 1);
      fd_strobe = 0;
      mode = 0;
    end
    probe_rdata = pd;
    if (mode == 0 || mode == 2) begin probe_wr = 1; probe_val = 0; end
    if (mode == 1 || mode == 2) begin fd_strobe = 1; fd_bit = 0; end
    #1;
    chk(core_req_ready == 1 && stall == 0, mode == 2 ? "R12 joint completion" :
        (mode == 1 ? "R7 fast-data completion" : "R6 clear completion"), core_req_ready, 1);
    if (!we) chk(core_rdata == pd, "R6 read data returned", core_rdata, pd);
    @(negedge clk);
    idle();
    #1;
    chk(pend == 0, "R6 pend cleared", pend, 0);
    chk(probe_err == 0, "R12 no error after completion", probe_err, 0);
  endtask

  task automatic mem_access(input logic [63:0] a, input bit rdy, input logic [31:0] md);
    @(negedge clk);
    core_req_valid = 1; core_addr = a; core_we = 0; mem_req_ready = rdy; mem_rdata = md;
    #1;
    chk(mem_req_valid == 1 && stall == 0, "R8 forwarded", mem_req_valid, 1);
    chk(core_req_ready == rdy, "R8 ready follows memory", core_req_ready, rdy);
    if (rdy) chk(core_rdata == md, "R8 read data", core_rdata, md);
    @(negedge clk);
    idle(); mem_req_ready = 0;
    #1;
    chk(pend == 0, "R8 no pend", pend, 0);
  endtask

  task automatic reg_access(input logic [63:0] a);
    @(negedge clk);
    core_req_valid = 1; core_addr = a; core_we = 0; mem_req_ready = 1; mem_rdata = 32'hDEAD_BEEF;
    #1;
    chk(core_req_ready == 1 && core_rdata == 0, "R9 register window accepted", core_rdata, 0);
    chk(mem_req_valid == 0 && stall == 0, "R9 no memory request", mem_req_valid, 0);
    @(negedge clk);
    idle(); mem_req_ready = 0;
    #1;
    chk(pend == 0, "R9 no pend", pend, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    void'($urandom(32'h1D5E_ED01));
    repeat (3) @(negedge clk);
    #1;
    chk(pend == 0 && stall == 0 && probe_err == 0 && core_req_ready == 0, "R1 reset state",
        {pend, stall, probe_err, core_req_ready}, 0);
    rst_n = 1;
    // directed boundaries
    dm_access(DM_BASE, 0, 32'h0, 32'h1234_5678, 0, 1);
    dm_access(DM_TOP, 1, 32'hCAFE_0001, 32'h0, 0, 2);
    dm_access(DM_BASE + 64'hC, 0, 32'h0, 32'hA5A5_0F0F, 1, 1);
    dm_access(DM_BASE + 64'h10, 0, 32'h0, 32'h0BAD_F00D, 1, 0);
    dm_access(DM_BASE + 64'h4, 0, 32'h0, 32'h7777_1111, 2, 0);
    reg_access(DR_BASE);
    reg_access(DR_TOP);
    mem_access(DM_BASE - 64'h4, 1, 32'h1111_2222);
    mem_access(DR_TOP + 64'h1, 1, 32'h3333_4444);
    mem_access(64'h0000_0000_FF20_0000, 0, 32'h0);
    // clear with nothing pending
    @(negedge clk); probe_wr = 1; probe_val = 0;
    @(negedge clk); idle(); #1;
    chk(probe_err == 1, "R11 error flagged", probe_err, 1);
    @(negedge clk); #1;
    chk(probe_err == 0, "R11 error one cycle", probe_err, 0);
    // clear in the capture cycle of a new request
    @(negedge clk);
    core_req_valid = 1; core_addr = DM_BASE + 64'h40; core_we = 0; probe_wr = 1; probe_val = 0;
    @(negedge clk); probe_wr = 0; #1;
    chk(probe_err == 1 && pend == 1, "R11 stale clear does not cancel capture", {pend, probe_err}, 3);
    probe_wr = 1; probe_val = 0; probe_rdata = 32'h55;
    #1;
    chk(core_req_ready == 1 && core_rdata == 32'h55, "R6 completion after stale clear", core_rdata, 32'h55);
    @(negedge clk); idle(); #1;
    chk(pend == 0, "R6 pend cleared", pend, 0);
    // constrained random
    for (int k = 0; k < 300; k++) begin
      int sel = $urandom_range(0, 2);
      if (sel == 1) begin
        a = DM_BASE + {44'd0, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 20'hFFFFF)};
        dm_access(a, $urandom_range(0, 1), $urandom, $urandom, $urandom_range(0, 2), $urandom_range(0, 3));
      end else if (sel == 2) begin
        a = DR_BASE + {44'd0, 20'($urandom)};
        reg_access(a);
      end else begin
        a = {$urandom, $urandom};
        if (region(a) == 0) mem_access(a, $urandom_range(0, 1), $urandom);
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule